// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns a serial input line into parallel characters. It oversamples the line with a 16x clock enable. The enable comes from one of two sources: the receiver's own external-rate tick or the transmitter's rate tick. A configuration input chooses the source. Software configuration sets the word length (5 to 8 bits), parity (off, even or odd) and a long-stop option. Each finished character is placed in a data register. A full flag, a receive interrupt and three error flags (parity, framing and overrun) come with it.

A host reads the data register and pulses a read strobe, which empties the register. A low-active carrier-detect input gates the receiver. While the carrier is absent the receiver is held idle. Its interrupt also stays masked from the moment the carrier is lost until a new start bit is confirmed.

Top module: `serial_rx`

## Requirements
- R1: Data bits are received least significant first. The word-length code `wlen` gives 5 + `wlen` data bits. The register bits above the word length read as 0.
- R2: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. On a mismatch `par_err`=1. The parity bit is never stored in `rx_data`.
- R3: `rx_full` sets when a character is transferred to `rx_data`. A one-cycle `rd_strobe` clears it.
- R4: Count ticks from the start of the first stop bit. With one stop bit, `rx_full` is visible after the 8th tick. When `stop_long`=1 with 5-bit words and no parity, the block uses one and a half stop bits and flags the character 12 ticks later. When `stop_long`=1 with 8-bit words and parity, one stop bit is used. In every other case `stop_long`=1 gives two stop bits, and the character is flagged 16 ticks later.
- R5: `frm_err`=1 when the sample at the middle of the first stop bit is low. Otherwise it is 0.
- R6: If a character completes while `rx_full` is still set, `rx_data` keeps the old character and `ovr_err` sets. A read clears `ovr_err`.
- R7: A falling edge on the line counts as a start bit only if the line is still low at the 8th tick after the edge. Otherwise the receiver returns to idle and no character results.
- R8: `clk_sel`=0 uses `tick_ext` as the 16x enable. `clk_sel`=1 uses `tick_tx`.
- R9: While `carrier_n`=1 the receiver stays idle and accepts no character. From carrier loss until the next confirmed start bit, `irq` is held at 0.
- R10: After reset, `rx_full`, `irq`, all error flags and `rx_data` are 0.
- R11: `irq`=1 while a character is waiting and the receiver is armed. A read drops it. The error flags never hold it up: `par_err` survives the read while `irq` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial data line, idle high |
| carrier_n | input | 1 | Carrier detect, low when carrier present |
| tick_ext | input | 1 | 16x enable from the receiver's own clock |
| tick_tx | input | 1 | 16x enable at the transmitter's rate |
| clk_sel | input | 1 | 0: use tick_ext, 1: use tick_tx |
| wlen | input | 2 | Word length code, data bits = 5 + wlen |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_long | input | 1 | Long stop option (1.5 or 2 stop bits) |
| rd_strobe | input | 1 | Host read of the data register |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Data register holds an unread character |
| par_err | output | 1 | Parity mismatch on the held character |
| frm_err | output | 1 | First stop bit sampled low |
| ovr_err | output | 1 | A character was lost to an unread register |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench keeps the default parameters: 8-bit data register, 16x oversampling and a two-stage synchronizer. With these values all four word lengths are reachable, and so are both parity senses. The three-quarter-bit tail of the 1.5-stop case is reachable as well; it is 12 ticks at this oversampling ratio. The two tick sources run at different periods, 4 and 6 cycles. As a result, picking the wrong source garbles the character. The stop-bit timing can also be measured to the exact tick.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int          STAGES = 2,
  parameter int          W      = 2,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= INIT;
    else     stg[0] <= d;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= INIT;
        else     stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              lost,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_long,
  output logic              done,
  output logic              start_ok,
  output logic [DATA_W-1:0] dout,
  output logic              pe_o,
  output logic              fe_o
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int NB_W    = $clog2(DATA_W + 1);
  localparam int HALF    = OVS / 2;
  localparam int TAIL_HB = (OVS * 3) / 4;
  localparam int MIN_LEN = DATA_W - 3;

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [DATA_W-1:0]  sh;
  logic               par_acc, pe_q, fe_q;
  logic [NB_W-1:0]    nbits, shamt;
  logic               use_tail, half_stop;
  logic [CNT_W-1:0]   tail_last;
  logic               last_bit, bit_end;

  always_comb begin
    nbits     = NB_W'(MIN_LEN) + NB_W'(wlen);
    shamt     = NB_W'(DATA_W) - nbits;
    half_stop = stop_long && (wlen == 2'd0) && !par_en;
    use_tail  = stop_long && !((wlen == 2'd3) && par_en);
    tail_last = half_stop ? CNT_W'(TAIL_HB - 1) : CNT_W'(OVS - 1);
    last_bit  = (NB_W'(bit_idx) + NB_W'(1)) == nbits;
    bit_end   = tick && (cnt == CNT_W'(OVS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      par_acc  <= 1'b0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
      done     <= 1'b0;
      start_ok <= 1'b0;
      dout     <= '0;
      pe_o     <= 1'b0;
      fe_o     <= 1'b0;
    end else begin
      done     <= 1'b0;
      start_ok <= 1'b0;
      if (lost) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!rx_s) state <= ST_START;
          end
          ST_START: if (tick) begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              if (!rx_s) begin
                state    <= ST_DATA;
                bit_idx  <= '0;
                sh       <= '0;
                par_acc  <= 1'b0;
                pe_q     <= 1'b0;
                start_ok <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_DATA: if (tick) begin
            cnt <= cnt + CNT_W'(1);
            if (bit_end) begin
              sh      <= {rx_s, sh[DATA_W-1:1]};
              par_acc <= par_acc ^ rx_s;
              if (last_bit) state <= par_en ? ST_PAR : ST_STOP;
              else          bit_idx <= bit_idx + BIT_W'(1);
            end
          end
          ST_PAR: if (tick) begin
            cnt <= cnt + CNT_W'(1);
            if (bit_end) begin
              pe_q  <= (par_acc ^ rx_s) != par_odd;
              state <= ST_STOP;
            end
          end
          ST_STOP: if (tick) begin
            cnt <= cnt + CNT_W'(1);
            if (bit_end) begin
              cnt  <= '0;
              fe_q <= !rx_s;
              if (use_tail) begin
                state <= ST_TAIL;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
                dout  <= sh >> shamt;
                pe_o  <= pe_q;
                fe_o  <= !rx_s;
              end
            end
          end
          ST_TAIL: if (tick) begin
            if (cnt == tail_last) begin
              cnt   <= '0;
              state <= ST_IDLE;
              done  <= 1'b1;
              dout  <= sh >> shamt;
              pe_o  <= pe_q;
              fe_o  <= fe_q;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_LOST_IDLES: assert property (@(posedge clk) disable iff (rst)
    lost |=> (state == ST_IDLE) && !done); // R9
  AST_HIGH_NO_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && rx_s |=> (state != ST_START)); // R7
  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> $past(!rx_s)); // R7
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              start_ok,
  input  logic              lost,
  input  logic              rd,
  input  logic [DATA_W-1:0] din,
  input  logic              pe_in,
  input  logic              fe_in,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              pe,
  output logic              fe,
  output logic              ovr,
  output logic              irq
);
  logic              armed, armed_n, full_n, ovr_n, load;

  always_comb begin
    load    = done && (!full || rd);
    armed_n = lost ? 1'b0 : (start_ok ? 1'b1 : armed);
    full_n  = full;
    ovr_n   = ovr;
    if (load) begin
      full_n = 1'b1;
      ovr_n  = 1'b0;
    end else if (done) begin
      ovr_n  = 1'b1;
    end else if (rd) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      full  <= 1'b0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      ovr   <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      armed <= armed_n;
      full  <= full_n;
      ovr   <= ovr_n;
      irq   <= full_n && armed_n;
      if (load) begin
        data <= din;
        pe   <= pe_in;
        fe   <= fe_in;
      end
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd && !done |=> !full && !ovr); // R3
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    done && full && !rd |=> $stable(data) && ovr); // R6
  AST_LOST_MASKS_IRQ: assert property (@(posedge clk) disable iff (rst)
    lost |=> !irq); // R9
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    rd && !done |=> !irq); // R11
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              carrier_n,
  input  logic              tick_ext,
  input  logic              tick_tx,
  input  logic              clk_sel,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_long,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              irq
);
  logic [1:0]        sync_q;
  logic              rx_s, lost, tick;
  logic              done, start_ok, pe_w, fe_w;
  logic [DATA_W-1:0] dout_w;

  assign tick = clk_sel ? tick_tx : tick_ext;

  rx_sync #(.STAGES(SYNC_STAGES), .W(2), .INIT(2'b11)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({carrier_n, rx_in}),
    .q   (sync_q)
  );
  assign lost = sync_q[1];
  assign rx_s = sync_q[0];

  rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rx_s      (rx_s),
    .lost      (lost),
    .wlen      (wlen),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .stop_long (stop_long),
    .done      (done),
    .start_ok  (start_ok),
    .dout      (dout_w),
    .pe_o      (pe_w),
    .fe_o      (fe_w)
  );

  rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .start_ok (start_ok),
    .lost     (lost),
    .rd       (rd_strobe),
    .din      (dout_w),
    .pe_in    (pe_w),
    .fe_in    (fe_w),
    .data     (rx_data),
    .full     (rx_full),
    .pe       (par_err),
    .fe       (frm_err),
    .ovr      (ovr_err),
    .irq      (irq)
  );
endmodule

// File: tb/test_serial_rx.sv
module test_serial_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       carrier_n = 1'b0;
  logic       tick_ext, tick_tx, sel_tick;
  logic       clk_sel = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_long = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, par_err, frm_err, ovr_err, irq;
  int         total = 0, bad = 0;
  int         ce = 0, ct = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ce <= (ce == 3) ? 0 : ce + 1;
    ct <= (ct == 5) ? 0 : ct + 1;
  end
  assign tick_ext = (ce == 0);
  assign tick_tx  = (ct == 0);
  assign sel_tick = clk_sel ? tick_tx : tick_ext;

  serial_rx i_serial_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .carrier_n(carrier_n),
    .tick_ext(tick_ext), .tick_tx(tick_tx), .clk_sel(clk_sel),
    .wlen(wlen), .par_en(par_en), .par_odd(par_odd), .stop_long(stop_long),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err), .irq(irq)
  );

  // {ticks5, exp_pe, exp_data8, bad_par, stop_long, par_odd, par_en, wlen2, din8}
  localparam logic [27:0] VEC [8] = '{
    {5'd8,  1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'hA5},
    {5'd20, 1'b0, 8'h1F, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'hFF},
    {5'd24, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 8'h3C},
    {5'd8,  1'b1, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 8'h55},
    {5'd8,  1'b0, 8'h81, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 8'h81},
    {5'd24, 1'b0, 8'h6B, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 8'h6B},
    {5'd24, 1'b0, 8'h07, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'hE7},
    {5'd8,  1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic one_tick();
    do @(posedge clk); while (!sel_tick);
    #2;
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_low,
                      output int first_full);
    int  nb;
    logic pb;
    nb = 5 + int'(wlen);
    one_tick();
    rx_in = 1'b0;
    repeat (16) one_tick();
    pb = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      pb    = pb ^ d[i];
      repeat (16) one_tick();
    end
    if (par_en) begin
      rx_in = pb ^ par_odd ^ bad_par;
      repeat (16) one_tick();
    end
    rx_in = stop_low ? 1'b0 : 1'b1;
    first_full = 0;
    for (int k = 1; k <= 32; k++) begin
      one_tick();
      if (k == 12) rx_in = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      if (rx_full && first_full == 0) first_full = k;
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int ft;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 full", rx_full, 0);
    chk("R10 irq", irq, 0);
    chk("R10 errors", {par_err, frm_err, ovr_err}, 0);
    chk("R10 data", rx_data, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [27:0] e;
      e = VEC[v];
      wlen = e[9:8]; par_en = e[10]; par_odd = e[11]; stop_long = e[12];
      send(e[7:0], e[13], 1'b0, ft);
      chk($sformatf("R1 data v%0d", v), rx_data, e[21:14]);
      chk($sformatf("R2 parity v%0d", v), par_err, e[22]);
      chk($sformatf("R5 no frame err v%0d", v), frm_err, 0);
      chk($sformatf("R3 full v%0d", v), rx_full, 1);
      chk($sformatf("R4 stop timing v%0d", v), ft, e[27:23]);
      chk($sformatf("R11 irq v%0d", v), irq, 1);
      do_read();
      chk($sformatf("R3 read clears v%0d", v), rx_full, 0);
      chk($sformatf("R11 irq drops v%0d", v), irq, 0);
      if (e[22]) chk("R11 parity flag survives read", par_err, 1);
    end

    // R5 framing error
    wlen = 2'd3; par_en = 1'b0; stop_long = 1'b0;
    send(8'h5A, 1'b0, 1'b1, ft);
    chk("R5 frame err", frm_err, 1);
    chk("R5 data", rx_data, 8'h5A);
    do_read();
    send(8'h5B, 1'b0, 1'b0, ft);
    chk("R5 frame err clears", frm_err, 0);
    do_read();

    // R6 overrun
    send(8'h11, 1'b0, 1'b0, ft);
    send(8'h22, 1'b0, 1'b0, ft);
    chk("R6 old data kept", rx_data, 8'h11);
    chk("R6 overrun set", ovr_err, 1);
    chk("R6 still full", rx_full, 1);
    do_read();
    chk("R6 overrun cleared", ovr_err, 0);
    chk("R6 full cleared", rx_full, 0);

    // R7 false start
    one_tick();
    rx_in = 1'b0;
    repeat (4) one_tick();
    rx_in = 1'b1;
    repeat (40) one_tick();
    chk("R7 false start ignored", rx_full, 0);
    send(8'h3A, 1'b0, 1'b0, ft);
    chk("R7 next char ok", rx_data, 8'h3A);
    do_read();

    // R8 transmitter-rate clock
    clk_sel = 1'b1;
    send(8'hC3, 1'b0, 1'b0, ft);
    chk("R8 tx rate data", rx_data, 8'hC3);
    chk("R8 tx rate full", rx_full, 1);
    do_read();
    clk_sel = 1'b0;

    // R9 carrier gating
    carrier_n = 1'b1;
    send(8'h77, 1'b0, 1'b0, ft);
    chk("R9 no char without carrier", rx_full, 0);
    carrier_n = 1'b0;
    repeat (4) one_tick();
    send(8'h78, 1'b0, 1'b0, ft);
    chk("R9 char after carrier", rx_data, 8'h78);
    chk("R9 irq after carrier", irq, 1);
    @(negedge clk) carrier_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 irq masked on loss", irq, 0);
    chk("R9 data kept on loss", rx_full, 1);
    carrier_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 irq stays masked", irq, 0);
    do_read();
    send(8'h79, 1'b0, 1'b0, ft);
    chk("R9 rearmed by start", irq, 1);
    chk("R9 rearmed data", rx_data, 8'h79);

    finished = 1'b1;
    report();
  end
endmodule